// File: doc/BRIEF.md
# UART Line Status and Receive-Error Tracker

This block produces the eight-bit line status word of a 16550-compatible serial port. It sits between the receive deserializer, a sixteen-entry receive queue and the transmit holding and shift path. Every character the deserializer completes arrives as a one-cycle strobe with its data byte and three error flags: parity mismatch, stop bit found low (framing), and line held low for a whole character frame (break). Both framing and break are detected upstream. The character and its flags are queued together, so the flags shown in the status word always belong to the character that the next data read will return.

Software reads the status word through a one-cycle read strobe. That read clears the sticky conditions: the overrun flag, the error flags of the current head character, and the queue-wide error summary. The summary clears only when no flagged character is left in the queue. The transmit side reports whether the holding register is free and whether both the holding and shift registers are idle. Bit timing, baud generation and interrupt priority lie outside the block. They reach it only as strobes and level inputs.

Top module: `uart_line_status`

## Requirements
- R1: Status bit 0 is 1 whenever the receive queue holds at least one unread character and 0 when it is empty.
- R2: Status bit 1 is set in the cycle after a character strobe arrives while the queue holds 16 characters. That character is discarded and the queue is unchanged. A status read clears the bit. A set in the same cycle as a read wins.
- R3: Status bits 2 (parity), 3 (framing) and 4 (break) show the flags stored with the head character, and are 0 while the queue is empty. A status read hides them for that head character. The next pop shows the flags of the following character.
- R4: `rbr_data` shows the head character. The queue is first-in first-out and 16 deep. A data read on an empty queue has no effect.
- R5: Status bit 5 is 1 when the holding register is empty. It reads 0 from the cycle after `thr_write`. It returns to 1 after a `thr_load` strobe with no write in the same cycle.
- R6: Status bit 6 is 1 only when the holding register is empty and `tsr_busy` is low.
- R7: Status bit 7 is set after a character with any error flag enters the queue. A status read clears it only if the count of flagged characters stored at that read is zero. A set in the same cycle as a read wins.
- R8: Status bit 7 reads 0 while `fifo_en` is 0.
- R9: During and right after reset the status word is 0x60 (with `tsr_busy` low), and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | Receive queue enable control; gates status bit 7 |
| rx_char_valid | input | 1 | Strobe: the deserializer has completed a character |
| rx_char_data | input | 8 | Completed character |
| rx_parity_err | input | 1 | Parity flag of the completed character |
| rx_frame_err | input | 1 | Stop-bit-low flag of the completed character |
| rx_break | input | 1 | Break flag of the completed character |
| rbr_read | input | 1 | Strobe: software reads the head character |
| rbr_data | output | 8 | Head character of the receive queue |
| thr_write | input | 1 | Strobe: software writes the holding register |
| thr_load | input | 1 | Strobe: the shift register takes the holding register |
| tsr_busy | input | 1 | The transmit shift register is still sending |
| lsr_read | input | 1 | Strobe: software reads the status word |
| lsr | output | 8 | Line status word |

## Verification
If the queue pointers or the count go wrong, `rbr_data` returns a character out of order, or bit 0 disagrees with the number of characters pushed and popped. This shows on the next data read. If the flag storage or the hide bit goes wrong, bits 2 to 4 show flags that belong to another character, or flags that a status read should have hidden. This shows in the cycle after the pop or the read. If the errored-entry count drifts, bit 7 clears too early or stays set after the last flagged character has drained. This shows at the first status read after that character leaves. The bench steps a model of the queue and flags alongside the design and compares every status bit and the head byte in every cycle.

// File: rtl/uls_pkg.sv
package uls_pkg;
  parameter int unsigned CHAR_W = 8;

  // status word bit positions (software-visible layout)
  localparam int unsigned LSR_DR   = 0;
  localparam int unsigned LSR_OVR  = 1;
  localparam int unsigned LSR_PAR  = 2;
  localparam int unsigned LSR_FRM  = 3;
  localparam int unsigned LSR_BRK  = 4;
  localparam int unsigned LSR_THRE = 5;
  localparam int unsigned LSR_TEMT = 6;
  localparam int unsigned LSR_RXFE = 7;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [CHAR_W-1:0] data;
  } rx_entry_t;

  function automatic logic entry_has_err(input rx_entry_t e);
    return e.brk | e.ferr | e.perr;
  endfunction
endpackage

// File: rtl/uls_rx_fifo.sv
module uls_rx_fifo
  import uls_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  logic      pop,
  input  rx_entry_t wr_entry,
  output rx_entry_t head,
  output logic      empty,
  output logic      full,
  output logic      err_none
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  rx_entry_t      mem [DEPTH];
  logic [AW-1:0]  wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]  rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [CW-1:0]  ecnt_q, ecnt_d;
  logic           err_in, err_out;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head     = mem[rd_ptr_q];
  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CW'(DEPTH));
  assign err_none = (ecnt_q == '0);
  assign err_in   = push & entry_has_err(wr_entry);
  assign err_out  = pop & entry_has_err(head);

  always_comb begin
    wr_ptr_d = push ? ptr_inc(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop  ? ptr_inc(rd_ptr_q) : rd_ptr_q;
    cnt_d    = cnt_q;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
    ecnt_d = ecnt_q;
    case ({err_in, err_out})
      2'b10:   ecnt_d = ecnt_q + 1'b1;
      2'b01:   ecnt_d = ecnt_q - 1'b1;
      default: ecnt_d = ecnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ecnt_q   <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      ecnt_q   <= ecnt_d;
    end
  end

  // storage: no reset, written only on an accepted push
  always_ff @(posedge clk) begin
    if (push) begin
      mem[wr_ptr_q] <= wr_entry;
    end
  end
endmodule

// File: rtl/uls_rx_status.sv
module uls_rx_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_strobe,
  input  logic       fifo_full,
  input  logic       fifo_empty,
  input  logic       push,
  input  logic       push_err,
  input  logic       pop,
  input  logic       err_none,
  input  logic       lsr_read,
  input  logic       fifo_en,
  input  logic [2:0] head_flags,
  output logic       overrun,
  output logic [2:0] head_flags_vis,
  output logic       rx_fifo_err
);
  logic ovr_q, ovr_d;
  logic hide_q, hide_d;
  logic rxfe_q, rxfe_d;

  always_comb begin
    // overrun: set beats clear
    if (rx_strobe && fifo_full) begin
      ovr_d = 1'b1;
    end else if (lsr_read) begin
      ovr_d = 1'b0;
    end else begin
      ovr_d = ovr_q;
    end
    // hide bit: a new head always shows its flags
    if (pop || fifo_empty) begin
      hide_d = 1'b0;
    end else if (lsr_read) begin
      hide_d = 1'b1;
    end else begin
      hide_d = hide_q;
    end
    // queue error summary: set beats clear, clear needs zero flagged entries
    if (push && push_err) begin
      rxfe_d = 1'b1;
    end else if (lsr_read && err_none) begin
      rxfe_d = 1'b0;
    end else begin
      rxfe_d = rxfe_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q  <= 1'b0;
      hide_q <= 1'b0;
      rxfe_q <= 1'b0;
    end else begin
      ovr_q  <= ovr_d;
      hide_q <= hide_d;
      rxfe_q <= rxfe_d;
    end
  end

  assign overrun        = ovr_q;
  assign head_flags_vis = (fifo_empty || hide_q) ? 3'b000 : head_flags;
  assign rx_fifo_err    = fifo_en & rxfe_q;
endmodule

// File: rtl/uls_tx_status.sv
module uls_tx_status (
  input  logic clk,
  input  logic rst_n,
  input  logic thr_write,
  input  logic thr_load,
  input  logic tsr_busy,
  output logic thr_empty,
  output logic tx_empty
);
  logic thr_full_q, thr_full_d;

  always_comb begin
    if (thr_write) begin
      thr_full_d = 1'b1;
    end else if (thr_load) begin
      thr_full_d = 1'b0;
    end else begin
      thr_full_d = thr_full_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_full_q <= 1'b0;
    end else begin
      thr_full_q <= thr_full_d;
    end
  end

  assign thr_empty = ~thr_full_q;
  assign tx_empty  = ~thr_full_q & ~tsr_busy;
endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
  import uls_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_en,
  input  logic       rx_char_valid,
  input  logic [7:0] rx_char_data,
  input  logic       rx_parity_err,
  input  logic       rx_frame_err,
  input  logic       rx_break,
  input  logic       rbr_read,
  output logic [7:0] rbr_data,
  input  logic       thr_write,
  input  logic       thr_load,
  input  logic       tsr_busy,
  input  logic       lsr_read,
  output logic [7:0] lsr
);
  rx_entry_t  wr_entry, head;
  logic       empty, full, err_none;
  logic       push, pop, push_err;
  logic       overrun, rx_fifo_err;
  logic [2:0] head_flags_vis;
  logic       thr_empty, tx_empty;

  assign wr_entry = '{brk: rx_break, ferr: rx_frame_err, perr: rx_parity_err,
                      data: rx_char_data};
  assign push     = rx_char_valid & ~full;
  assign pop      = rbr_read & ~empty;
  assign push_err = entry_has_err(wr_entry);

  uls_rx_fifo #(.DEPTH(FIFO_DEPTH)) fifo_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .pop      (pop),
    .wr_entry (wr_entry),
    .head     (head),
    .empty    (empty),
    .full     (full),
    .err_none (err_none)
  );

  uls_rx_status rx_stat_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_strobe      (rx_char_valid),
    .fifo_full      (full),
    .fifo_empty     (empty),
    .push           (push),
    .push_err       (push_err),
    .pop            (pop),
    .err_none       (err_none),
    .lsr_read       (lsr_read),
    .fifo_en        (fifo_en),
    .head_flags     ({head.brk, head.ferr, head.perr}),
    .overrun        (overrun),
    .head_flags_vis (head_flags_vis),
    .rx_fifo_err    (rx_fifo_err)
  );

  uls_tx_status tx_stat_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .thr_write (thr_write),
    .thr_load  (thr_load),
    .tsr_busy  (tsr_busy),
    .thr_empty (thr_empty),
    .tx_empty  (tx_empty)
  );

  assign rbr_data = empty ? '0 : head.data;

  always_comb begin
    lsr           = '0;
    lsr[LSR_DR]   = ~empty;
    lsr[LSR_OVR]  = overrun;
    lsr[LSR_PAR]  = head_flags_vis[0];
    lsr[LSR_FRM]  = head_flags_vis[1];
    lsr[LSR_BRK]  = head_flags_vis[2];
    lsr[LSR_THRE] = thr_empty;
    lsr[LSR_TEMT] = tx_empty;
    lsr[LSR_RXFE] = rx_fifo_err;
  end
endmodule

// File: rtl/uls_checker.sv
module uls_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_en,
  input logic       fifo_full,
  input logic       rx_char_valid,
  input logic       rx_parity_err,
  input logic       rx_frame_err,
  input logic       rx_break,
  input logic       rbr_read,
  input logic [7:0] rbr_data,
  input logic       thr_write,
  input logic       lsr_read,
  input logic [7:0] lsr
);
  AST_DR_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_char_valid && !lsr[0]) |=> lsr[0]); // R1

  AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_char_valid && fifo_full) |=> lsr[1]); // R2

  AST_OVR_KEEPS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_char_valid && fifo_full && !rbr_read) |=> $stable(rbr_data)); // R2

  AST_FLAGS_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_read && lsr[0] && !rbr_read) |=> (lsr[4:2] == 3'b000)); // R3

  AST_NO_FLAGS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !lsr[0] |-> (lsr[4:2] == 3'b000)); // R3

  AST_THRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    thr_write |=> !lsr[5]); // R5

  AST_TEMT_NEEDS_THRE: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[6] |-> lsr[5]); // R6

  AST_RXFE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_char_valid && !fifo_full && (rx_parity_err || rx_frame_err || rx_break))
      |=> (lsr[7] || !fifo_en)); // R7
endmodule

bind uart_line_status uls_checker chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .fifo_en       (fifo_en),
  .fifo_full     (full),
  .rx_char_valid (rx_char_valid),
  .rx_parity_err (rx_parity_err),
  .rx_frame_err  (rx_frame_err),
  .rx_break      (rx_break),
  .rbr_read      (rbr_read),
  .rbr_data      (rbr_data),
  .thr_write     (thr_write),
  .lsr_read      (lsr_read),
  .lsr           (lsr)
);

// File: tb/uart_line_status_tb.sv
module uart_line_status_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b1;
  logic       rx_char_valid = 1'b0;
  logic [7:0] rx_char_data = '0;
  logic       rx_parity_err = 1'b0, rx_frame_err = 1'b0, rx_break = 1'b0;
  logic       rbr_read = 1'b0, thr_write = 1'b0, thr_load = 1'b0;
  logic       tsr_busy = 1'b0, lsr_read = 1'b0;
  logic [7:0] rbr_data, lsr;

  int checks = 0;
  int errors = 0;

  // bench model state: entry = {brk, ferr, perr, data}
  bit [10:0] mq[$];
  bit        m_ovr = 0, m_hide = 0, m_rxfe = 0, m_thr = 0;
  int        m_ecnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_line_status #(.FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
    .rx_char_valid(rx_char_valid), .rx_char_data(rx_char_data),
    .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err), .rx_break(rx_break),
    .rbr_read(rbr_read), .rbr_data(rbr_data),
    .thr_write(thr_write), .thr_load(thr_load), .tsr_busy(tsr_busy),
    .lsr_read(lsr_read), .lsr(lsr)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit [2:0] exp_flags();
    if (mq.size() == 0 || m_hide) return 3'b000;
    return mq[0][10:8];
  endfunction

  task automatic compare(input bit busy, input bit fen);
    chk("R1 data ready", {7'd0, lsr[0]}, {7'd0, mq.size() != 0});
    chk("R2 overrun", {7'd0, lsr[1]}, {7'd0, m_ovr});
    chk("R3 head flags", {5'd0, lsr[4:2]}, {5'd0, exp_flags()});
    chk("R5 holding empty", {7'd0, lsr[5]}, {7'd0, !m_thr});
    chk("R6 transmitter empty", {7'd0, lsr[6]}, {7'd0, !m_thr && !busy});
    if (fen) chk("R7 queue error", {7'd0, lsr[7]}, {7'd0, m_rxfe});
    else     chk("R8 queue error masked", {7'd0, lsr[7]}, 8'd0);
    if (mq.size() != 0) chk("R4 head data", rbr_data, mq[0][7:0]);
  endtask

  // one clock: drive at negedge, advance the model, check after the edge
  task automatic step(input bit v, input bit [7:0] d, input bit [2:0] fl,
                      input bit rr, input bit lr, input bit tw, input bit tl,
                      input bit busy, input bit fen);
    bit empty, full, pop, push, errin;
    bit n_ovr, n_hide, n_rxfe;
    @(negedge clk);
    rx_char_valid = v; rx_char_data = d;
    rx_parity_err = fl[0]; rx_frame_err = fl[1]; rx_break = fl[2];
    rbr_read = rr; lsr_read = lr; thr_write = tw; thr_load = tl;
    tsr_busy = busy; fifo_en = fen;
    empty = (mq.size() == 0);
    full  = (mq.size() == DEPTH);
    pop   = rr && !empty;
    push  = v && !full;
    errin = |fl;
    n_ovr  = (v && full) ? 1'b1 : (lr ? 1'b0 : m_ovr);
    n_hide = (pop || empty) ? 1'b0 : (lr ? 1'b1 : m_hide);
    n_rxfe = (push && errin) ? 1'b1 : ((lr && m_ecnt == 0) ? 1'b0 : m_rxfe);
    if (pop) begin
      if (|mq[0][10:8]) m_ecnt--;
      void'(mq.pop_front());
    end
    if (push) begin
      mq.push_back({fl, d});
      if (errin) m_ecnt++;
    end
    m_thr  = tw ? 1'b1 : (tl ? 1'b0 : m_thr);
    m_ovr  = n_ovr;
    m_hide = n_hide;
    m_rxfe = n_rxfe;
    @(posedge clk);
    #1;
    compare(busy, fen);
  endtask

  task automatic push_ch(input bit [7:0] d, input bit [2:0] fl);
    step(1, d, fl, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic idle(input bit rr, input bit lr);
    step(0, 8'h00, 3'b000, rr, lr, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5a17));
    // R9: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R9 status during reset", lsr, 8'h60);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R9 status after reset", lsr, 8'h60);
    idle(0, 0);

    // R3/R7: per-character flags, hide on status read, summary clear rule
    push_ch(8'h11, 3'b000);
    push_ch(8'h22, 3'b001);
    push_ch(8'h33, 3'b010);
    push_ch(8'h44, 3'b100);
    idle(0, 1);            // R7 stays set: flagged entries remain
    idle(1, 0);            // R3 parity of 0x22 visible
    idle(0, 1);            // R3 hidden for 0x22
    idle(1, 0);            // R3 framing of 0x33
    idle(1, 1);            // pop with read: break of 0x44 shows
    idle(1, 0);            // queue empty
    idle(0, 1);            // R7 clears: no flagged entry left
    idle(1, 0);            // R4 read on empty ignored

    // R2: fill, overrun, set beats clear, clear by read
    for (int i = 0; i < DEPTH; i++) push_ch(8'(8'h80 + i), 3'b000);
    push_ch(8'hEE, 3'b011);
    step(1, 8'hEF, 3'b000, 0, 1, 0, 0, 0, 1);
    idle(0, 1);
    step(1, 8'h5A, 3'b000, 1, 0, 0, 0, 0, 1);  // full at edge: still dropped
    for (int i = 0; i < DEPTH + 1; i++) idle(1, 0);

    // R5/R6: transmit path
    step(0, 0, 0, 0, 0, 1, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1, 1, 1);
    step(0, 0, 0, 0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1, 1, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1, 0, 1);

    // R8: enable low masks the summary
    step(1, 8'h66, 3'b100, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    idle(0, 0);
    idle(1, 1);
    idle(0, 1);

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      bit [2:0] fl;
      fl[0] = ($urandom % 8) == 0;
      fl[1] = ($urandom % 8) == 0;
      fl[2] = ($urandom % 10) == 0;
      step(($urandom % 2) == 0, 8'($urandom), fl,
           ($urandom % 5) < 2, ($urandom % 5) == 0,
           ($urandom % 5) == 0, ($urandom % 4) == 0,
           ($urandom % 2) == 0, ($urandom % 10) != 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule